// File: doc/BRIEF.md
# Pin I/O Controller with Level and Edge Interrupt Capture

This block is a register-mapped general-purpose pin controller for up to 32 pins, reached through a simple 32-bit bus with separate read and write strobes, a byte address and write data. For every pin it holds separate enables for input sampling, output drive and a pull-up. It also holds a per-pin output inversion mask and the data to drive. From these and from a modelled external driver (an enable and a value per pin) it works out the level on each pin. It then samples that level into a read-only value register.

Each pin has four sticky pending flags: level high, level low, rising edge and falling edge. Each flag has an enable bit, and a pin's interrupt line is the OR of its four enabled flags. Software clears a flag by writing a one to its bit. A level flag whose condition still holds is set again in the same clock. A few registers exist only as storage, with no effect on the pins: drive strength, alternate-function enable and alternate-function select. A per-pin short-circuit flag reports a pin that is driven from outside while its own output is enabled.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register, the stored input value and every pending flag are zero, so `pin_oe`, `pin_out` and `pin_irq` are all zero; at the first clock after reset the low-level flags of all pins become 1.
- R2: `pin_oe` equals the output-enable register, and `pin_out` bit i is output-enable[i] AND (data[i] XOR invert[i]).
- R3: The resolved level of pin i is `ext_drv_val[i]` when `ext_drv_en[i]` is 1. Otherwise it is `pin_out[i]` when output-enable[i] is 1. Otherwise it is pull-up[i].
- R4: The value register (offset 0x00) holds input-enable[i] AND level[i] for each bit i, captured at every clock edge, and writes to it have no effect.
- R5: Each high flag is set at a clock edge where the input value of its pin is 1, and each low flag where it is 0. Both stay set until cleared, and a clear that lands while the condition holds leaves the flag at 1.
- R6: A rise flag is set at an edge where the input value is 1 and the stored value is 0. A fall flag is set where the input value is 0 and the stored value is 1.
- R7: A write to a pending offset clears exactly the flags whose write-data bit is 1 and keeps the rest. A set condition in the same clock wins over the clear.
- R8: `pin_irq[i]` is the OR, over the four kinds, of flag[i] AND enable[i].
- R9: The drive-strength, alternate-enable and alternate-select registers read back what was written and change no pin output.
- R10: `bus_rdata` is combinational and valid while `bus_rd` is 1, and zero while it is 0. A read of an unmapped or unaligned address returns zero, and a write to one changes nothing.
- R11: `short_err[i]` is 1 exactly when `ext_drv_en[i]` and output-enable[i] are both 1.
- R12: Register offsets: value 0x00, input-enable 0x04, output-enable 0x08, data 0x0C, pull-up 0x10, drive strength 0x14, rise enable 0x18, rise flags 0x1C, fall enable 0x20, fall flags 0x24, high enable 0x28, high flags 0x2C, low enable 0x30, low flags 0x34, alternate enable 0x38, alternate select 0x3C, invert 0x40. Bit i of each register belongs to pin i, and every register reads back its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, data taken at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ext_drv_en | input | NPINS | Pin is driven from outside |
| ext_drv_val | input | NPINS | Level driven from outside |
| pin_out | output | NPINS | Level the block drives |
| pin_oe | output | NPINS | Block drive enable per pin |
| pin_irq | output | NPINS | Interrupt line per pin |
| short_err | output | NPINS | Pin driven from both sides |

## Verification
A write-one clear of a pending register and a fresh set condition for the same flag can land on the same clock edge. The bench provokes this by starting a clear of all rise flags on the same falling edge that it switches on an external high drive for pin 0, and by clearing the high flags while their pins are still high. It expects the colliding bits to read 1 afterwards and every other cleared bit to read 0. The resolution priority is swept over all 128 combinations of the seven per-pin control inputs.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int unsigned REG_AW = 7;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned NKIND  = 4;

  localparam int unsigned KIND_RISE = 0;
  localparam int unsigned KIND_FALL = 1;
  localparam int unsigned KIND_HIGH = 2;
  localparam int unsigned KIND_LOW  = 3;

  typedef enum logic [REG_AW-1:0] {
    OFF_VALUE   = 7'h00,
    OFF_IN_EN   = 7'h04,
    OFF_OUT_EN  = 7'h08,
    OFF_PORT    = 7'h0C,
    OFF_PULL    = 7'h10,
    OFF_DRIVE   = 7'h14,
    OFF_RISE_IE = 7'h18,
    OFF_RISE_IP = 7'h1C,
    OFF_FALL_IE = 7'h20,
    OFF_FALL_IP = 7'h24,
    OFF_HIGH_IE = 7'h28,
    OFF_HIGH_IP = 7'h2C,
    OFF_LOW_IE  = 7'h30,
    OFF_LOW_IP  = 7'h34,
    OFF_ALT_EN  = 7'h38,
    OFF_ALT_SEL = 7'h3C,
    OFF_INVERT  = 7'h40
  } reg_off_e;

  // Level the block itself drives onto one pin.
  function automatic logic driven_level(input logic oe, input logic data, input logic inv);
    return oe & (data ^ inv);
  endfunction

  // Pin level: outside driver first, own driver second, pull-up last.
  function automatic logic resolve_level(input logic ext_en, input logic ext_val,
                                         input logic oe, input logic drv,
                                         input logic pull);
    if (ext_en)  return ext_val;
    if (oe)      return drv;
    return pull;
  endfunction

  // Sticky flag update: write-one clear, set condition wins.
  function automatic logic [BUS_W-1:0] next_pending(input logic [BUS_W-1:0] cur,
                                                    input logic [BUS_W-1:0] clr,
                                                    input logic [BUS_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Offset of the flag register for one pending kind.
  function automatic reg_off_e pend_offset(input int unsigned kind);
    case (kind)
      KIND_RISE: return OFF_RISE_IP;
      KIND_FALL: return OFF_FALL_IP;
      KIND_HIGH: return OFF_HIGH_IP;
      default:   return OFF_LOW_IP;
    endcase
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    addr,
  input  logic [NPINS-1:0]     wdata,
  output logic [NPINS-1:0]     in_en_q,
  output logic [NPINS-1:0]     out_en_q,
  output logic [NPINS-1:0]     port_q,
  output logic [NPINS-1:0]     pull_q,
  output logic [NPINS-1:0]     inv_q,
  output logic [NPINS-1:0]     rise_ie_q,
  output logic [NPINS-1:0]     fall_ie_q,
  output logic [NPINS-1:0]     high_ie_q,
  output logic [NPINS-1:0]     low_ie_q,
  output logic [NPINS-1:0]     drive_q,
  output logic [NPINS-1:0]     alt_en_q,
  output logic [NPINS-1:0]     alt_sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en_q   <= '0;
      out_en_q  <= '0;
      port_q    <= '0;
      pull_q    <= '0;
      inv_q     <= '0;
      rise_ie_q <= '0;
      fall_ie_q <= '0;
      high_ie_q <= '0;
      low_ie_q  <= '0;
      drive_q   <= '0;
      alt_en_q  <= '0;
      alt_sel_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_IN_EN:   in_en_q   <= wdata;
        OFF_OUT_EN:  out_en_q  <= wdata;
        OFF_PORT:    port_q    <= wdata;
        OFF_PULL:    pull_q    <= wdata;
        OFF_INVERT:  inv_q     <= wdata;
        OFF_RISE_IE: rise_ie_q <= wdata;
        OFF_FALL_IE: fall_ie_q <= wdata;
        OFF_HIGH_IE: high_ie_q <= wdata;
        OFF_LOW_IE:  low_ie_q  <= wdata;
        OFF_DRIVE:   drive_q   <= wdata;
        OFF_ALT_EN:  alt_en_q  <= wdata;
        OFF_ALT_SEL: alt_sel_q <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0] in_en,
  input  logic [NPINS-1:0] out_en,
  input  logic [NPINS-1:0] port,
  input  logic [NPINS-1:0] inv,
  input  logic [NPINS-1:0] pull,
  input  logic [NPINS-1:0] ext_en,
  input  logic [NPINS-1:0] ext_val,
  output logic [NPINS-1:0] drv_level,
  output logic [NPINS-1:0] pin_level,
  output logic [NPINS-1:0] in_val,
  output logic [NPINS-1:0] short_err
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign drv_level[p] = driven_level(out_en[p], port[p], inv[p]);
    assign pin_level[p] = resolve_level(ext_en[p], ext_val[p], out_en[p],
                                        drv_level[p], pull[p]);
    assign in_val[p]    = in_en[p] & pin_level[p];
    assign short_err[p] = ext_en[p] & out_en[p];
  end

endmodule

// File: rtl/gpio_event_track.sv
module gpio_event_track
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  in_val,
  input  logic [NPINS-1:0]  rise_ie,
  input  logic [NPINS-1:0]  fall_ie,
  input  logic [NPINS-1:0]  high_ie,
  input  logic [NPINS-1:0]  low_ie,
  output logic [NPINS-1:0]  value_q,
  output logic [NPINS-1:0]  rise_ip,
  output logic [NPINS-1:0]  fall_ip,
  output logic [NPINS-1:0]  high_ip,
  output logic [NPINS-1:0]  low_ip,
  output logic [NPINS-1:0]  irq
);

  logic [NPINS-1:0] set_v [NKIND];
  logic [NPINS-1:0] ie_v  [NKIND];
  logic [NPINS-1:0] ip_q  [NKIND];

  assign set_v[KIND_RISE] = in_val & ~value_q;
  assign set_v[KIND_FALL] = ~in_val & value_q;
  assign set_v[KIND_HIGH] = in_val;
  assign set_v[KIND_LOW]  = ~in_val;

  assign ie_v[KIND_RISE] = rise_ie;
  assign ie_v[KIND_FALL] = fall_ie;
  assign ie_v[KIND_HIGH] = high_ie;
  assign ie_v[KIND_LOW]  = low_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= in_val;
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    localparam reg_off_e MY_OFF = pend_offset(k);
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] flags;

    assign clr = (wr_en && (addr == MY_OFF)) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= NPINS'(next_pending(BUS_W'(flags), BUS_W'(clr), BUS_W'(set_v[k])));
    end

    assign ip_q[k] = flags;
  end

  assign rise_ip = ip_q[KIND_RISE];
  assign fall_ip = ip_q[KIND_FALL];
  assign high_ip = ip_q[KIND_HIGH];
  assign low_ip  = ip_q[KIND_LOW];

  always_comb begin
    irq = '0;
    for (int k = 0; k < NKIND; k++) irq |= ip_q[k] & ie_v[k];
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  ext_drv_en,
  input  logic [NPINS-1:0]  ext_drv_val,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_irq,
  output logic [NPINS-1:0]  short_err
);

  logic [NPINS-1:0] in_en, out_en, port, pull, inv;
  logic [NPINS-1:0] rise_ie, fall_ie, high_ie, low_ie;
  logic [NPINS-1:0] drive, alt_en, alt_sel;
  logic [NPINS-1:0] pin_level, in_val, value_q;
  logic [NPINS-1:0] rise_ip, fall_ip, high_ip, low_ip;
  logic [NPINS-1:0] any_ie;
  logic [NPINS-1:0] wdata_n;
  logic [BUS_W-1:0] rd_word;

  assign wdata_n = bus_wdata[NPINS-1:0];
  assign any_ie  = rise_ie | fall_ie | high_ie | low_ie;
  assign pin_oe  = out_en;

  gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (wdata_n),
    .in_en_q  (in_en),
    .out_en_q (out_en),
    .port_q   (port),
    .pull_q   (pull),
    .inv_q    (inv),
    .rise_ie_q(rise_ie),
    .fall_ie_q(fall_ie),
    .high_ie_q(high_ie),
    .low_ie_q (low_ie),
    .drive_q  (drive),
    .alt_en_q (alt_en),
    .alt_sel_q(alt_sel)
  );

  gpio_pin_resolve #(.NPINS(NPINS)) u_resolve (
    .in_en    (in_en),
    .out_en   (out_en),
    .port     (port),
    .inv      (inv),
    .pull     (pull),
    .ext_en   (ext_drv_en),
    .ext_val  (ext_drv_val),
    .drv_level(pin_out),
    .pin_level(pin_level),
    .in_val   (in_val),
    .short_err(short_err)
  );

  gpio_event_track #(.NPINS(NPINS)) u_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (wdata_n),
    .in_val (in_val),
    .rise_ie(rise_ie),
    .fall_ie(fall_ie),
    .high_ie(high_ie),
    .low_ie (low_ie),
    .value_q(value_q),
    .rise_ip(rise_ip),
    .fall_ip(fall_ip),
    .high_ip(high_ip),
    .low_ip (low_ip),
    .irq    (pin_irq)
  );

  function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_W-1:0] w;
    w = '0;
    w[NPINS-1:0] = v;
    return w;
  endfunction

  always_comb begin
    case (bus_addr)
      OFF_VALUE:   rd_word = widen(value_q);
      OFF_IN_EN:   rd_word = widen(in_en);
      OFF_OUT_EN:  rd_word = widen(out_en);
      OFF_PORT:    rd_word = widen(port);
      OFF_PULL:    rd_word = widen(pull);
      OFF_DRIVE:   rd_word = widen(drive);
      OFF_RISE_IE: rd_word = widen(rise_ie);
      OFF_RISE_IP: rd_word = widen(rise_ip);
      OFF_FALL_IE: rd_word = widen(fall_ie);
      OFF_FALL_IP: rd_word = widen(fall_ip);
      OFF_HIGH_IE: rd_word = widen(high_ie);
      OFF_HIGH_IP: rd_word = widen(high_ip);
      OFF_LOW_IE:  rd_word = widen(low_ie);
      OFF_LOW_IP:  rd_word = widen(low_ip);
      OFF_ALT_EN:  rd_word = widen(alt_en);
      OFF_ALT_SEL: rd_word = widen(alt_sel);
      OFF_INVERT:  rd_word = widen(inv);
      default:     rd_word = '0;
    endcase
    bus_rdata = bus_rd ? rd_word : '0;
  end

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [NPINS-1:0]  in_val,
  input logic [NPINS-1:0]  value_q,
  input logic [NPINS-1:0]  high_ip,
  input logic [NPINS-1:0]  low_ip,
  input logic [NPINS-1:0]  rise_ip,
  input logic [NPINS-1:0]  fall_ip,
  input logic [NPINS-1:0]  any_ie,
  input logic [NPINS-1:0]  pin_irq
);

  assert_value_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (value_q == $past(in_val)));

  assert_high_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_val != '0) |=> ((high_ip & $past(in_val)) == $past(in_val)));

  assert_low_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (~in_val != '0) |=> ((low_ip & ~$past(in_val)) == ~$past(in_val)));

  assert_rise_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_val & ~value_q) != '0) |=> ((rise_ip & $past(in_val & ~value_q)) == $past(in_val & ~value_q)));

  assert_fall_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~in_val & value_q) != '0) |=> ((fall_ip & $past(~in_val & value_q)) == $past(~in_val & value_q)));

  assert_high_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == OFF_HIGH_IP)) |=> ((high_ip & $past(high_ip)) == $past(high_ip)));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_irq & ~any_ie) == '0));

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (bus_wr),
  .addr   (bus_addr),
  .in_val (in_val),
  .value_q(value_q),
  .high_ip(high_ip),
  .low_ip (low_ip),
  .rise_ip(rise_ip),
  .fall_ip(fall_ip),
  .any_ie (any_ie),
  .pin_irq(pin_irq)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;
  import gpio_ctrl_pkg::*;

  localparam int unsigned NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] ext_drv_en = '0;
  logic [NP-1:0] ext_drv_val = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_irq, short_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_ctrl #(.NPINS(NP)) i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_drv_en(ext_drv_en), .ext_drv_val(ext_drv_val),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq), .short_err(short_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Called at a falling edge; reads half a cycle away from the next rising edge.
  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] pv, qv, exp_rise, exp_high, exp_fall;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(OFF_IN_EN, r);   chk("R1 in_en", r, 32'h0);
    rd(OFF_VALUE, r);   chk("R1 value", r, 32'h0);
    rd(OFF_RISE_IP, r); chk("R1 rise flags", r, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_irq", pin_irq, 32'h0);
    @(negedge clk);
    rd(OFF_LOW_IP, r);  chk("R1 R5 low flags after first clock", r, 32'hFFFF_FFFF);

    // Sweep of all 128 per-pin control combinations, 32 pins per pass
    for (int pass = 0; pass < 4; pass++) begin
      logic [NP-1:0] e_en, e_val, oe, dat, inv, pu, ie;
      logic [NP-1:0] x_out, x_val, x_short;
      for (int p = 0; p < NP; p++) begin
        int k;
        logic drv, lvl;
        k = pass * 32 + p;
        e_en[p] = k[0]; e_val[p] = k[1]; oe[p] = k[2]; dat[p] = k[3];
        inv[p]  = k[4]; pu[p]    = k[5]; ie[p] = k[6];
        drv = oe[p] ? (dat[p] ^ inv[p]) : 1'b0;
        if (e_en[p])    lvl = e_val[p];
        else if (oe[p]) lvl = drv;
        else            lvl = pu[p];
        x_out[p]   = drv;
        x_val[p]   = ie[p] & lvl;
        x_short[p] = e_en[p] & oe[p];
      end
      wr(OFF_IN_EN, ie);
      wr(OFF_OUT_EN, oe);
      wr(OFF_PORT, dat);
      wr(OFF_INVERT, inv);
      wr(OFF_PULL, pu);
      ext_drv_en = e_en; ext_drv_val = e_val;
      repeat (2) @(negedge clk);
      chk("R2 pin_out", pin_out, x_out);
      chk("R2 pin_oe", pin_oe, oe);
      rd(OFF_VALUE, r); chk("R3 R4 value register", r, x_val);
      chk("R11 short_err", short_err, x_short);
      rd(OFF_INVERT, r); chk("R12 invert readback", r, inv);
    end

    // Pending flags driven from the pull-up only
    pv = 32'hA5A5_0F0F;
    qv = 32'h0FF0_3C3C;
    ext_drv_en = '0; ext_drv_val = '0;
    wr(OFF_OUT_EN, 32'h0);
    wr(OFF_INVERT, 32'h0);
    wr(OFF_PORT, 32'h0);
    wr(OFF_IN_EN, 32'hFFFF_FFFF);
    wr(OFF_PULL, pv);
    repeat (2) @(negedge clk);
    wr(OFF_RISE_IP, 32'hFFFF_FFFF);
    wr(OFF_FALL_IP, 32'hFFFF_FFFF);
    wr(OFF_HIGH_IP, 32'hFFFF_FFFF);
    wr(OFF_LOW_IP, 32'hFFFF_FFFF);
    rd(OFF_HIGH_IP, r); chk("R5 high re-set after clear", r, pv);
    rd(OFF_LOW_IP, r);  chk("R5 low re-set after clear", r, ~pv);
    rd(OFF_RISE_IP, r); chk("R7 rise cleared", r, 32'h0);
    rd(OFF_FALL_IP, r); chk("R7 fall cleared", r, 32'h0);

    wr(OFF_PULL, qv);
    @(negedge clk);
    exp_rise = qv & ~pv;
    exp_fall = pv & ~qv;
    exp_high = pv | qv;
    rd(OFF_RISE_IP, r); chk("R6 rise flags", r, exp_rise);
    rd(OFF_FALL_IP, r); chk("R6 fall flags", r, exp_fall);
    rd(OFF_HIGH_IP, r); chk("R5 high sticky", r, exp_high);
    rd(OFF_LOW_IP, r);  chk("R5 low sticky", r, ~pv | ~qv);

    wr(OFF_RISE_IP, 32'h0000_FFFF);
    exp_rise = exp_rise & 32'hFFFF_0000;
    rd(OFF_RISE_IP, r); chk("R7 partial clear", r, exp_rise);

    wr(OFF_RISE_IE, 32'hFFFF_FFFF);
    chk("R8 irq from rise", pin_irq, exp_rise);
    wr(OFF_RISE_IE, 32'h0);
    wr(OFF_HIGH_IE, 32'hFFFF_0000);
    wr(OFF_FALL_IE, 32'h0000_00FF);
    chk("R8 irq high or fall", pin_irq, (exp_high & 32'hFFFF_0000) | (exp_fall & 32'h0000_00FF));

    // Clear and new rising edge on pin 0 in the same clock
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = OFF_RISE_IP; bus_wdata = 32'hFFFF_FFFF;
    ext_drv_en = 32'h1; ext_drv_val = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(OFF_RISE_IP, r); chk("R7 set wins over clear", r, 32'h1);
    wr(OFF_HIGH_IP, 32'hFFFF_FFFF);
    rd(OFF_HIGH_IP, r); chk("R5 R7 high held during clear", r, qv | 32'h1);

    wr(OFF_VALUE, 32'hFFFF_FFFF);
    rd(OFF_VALUE, r); chk("R4 value write ignored", r, qv | 32'h1);

    // Storage-only registers
    wr(OFF_OUT_EN, 32'hFFFF_FFFF);
    wr(OFF_PORT, 32'h1234_ABCD);
    chk("R2 pin_out direct", pin_out, 32'h1234_ABCD);
    chk("R11 short on pin 0", short_err, 32'h1);
    wr(OFF_DRIVE, 32'h5A5A_1234);
    wr(OFF_ALT_EN, 32'hDEAD_BEEF);
    wr(OFF_ALT_SEL, 32'hCAFE_F00D);
    rd(OFF_DRIVE, r);   chk("R9 drive readback", r, 32'h5A5A_1234);
    rd(OFF_ALT_EN, r);  chk("R9 alt enable readback", r, 32'hDEAD_BEEF);
    rd(OFF_ALT_SEL, r); chk("R9 alt select readback", r, 32'hCAFE_F00D);
    chk("R9 pin_out unchanged", pin_out, 32'h1234_ABCD);

    // Unmapped accesses
    rd(7'h44, r); chk("R10 unmapped read", r, 32'h0);
    rd(7'h0E, r); chk("R10 unaligned read", r, 32'h0);
    wr(7'h44, 32'hFFFF_FFFF);
    wr(7'h7C, 32'hFFFF_FFFF);
    wr(7'h0D, 32'h0);
    rd(OFF_PORT, r); chk("R10 R12 port after unmapped writes", r, 32'h1234_ABCD);
    chk("R10 pin_out after unmapped writes", pin_out, 32'h1234_ABCD);
    bus_addr = OFF_PORT; #1;
    chk("R10 rdata idle", bus_rdata, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule